// File: doc/BRIEF.md
# Power Path Switch Sequencer

This block decides whether the system load is fed from the adapter or from the battery, and drives one enable for the input FET pair and one for the battery FET. Its inputs are digitised comparator flags: adapter qualified, input over-voltage, sleep (input near or below the battery) and adapter-above-battery. A slowly changing or noisy flag must persist for a programmable number of clock ticks before it counts. Flags that call for removing a path take effect on the next clock edge.

The two enables are interlocked with a break-before-make gap. When the chosen path changes, the enable that is on drops at once. Both enables then stay low for a fixed dead time. At the end of that gap the block enables whichever path the inputs call for at that moment. An over-voltage flag or a settled sleep flag keeps the input pair off, so the battery cannot drive current back into the input.

Top module: `pp_switch_seq`

## Requirements
- R1: With steady inputs, once every delay has elapsed, `in_gate_en` is 1 and `bat_gate_en` is 0 exactly when `adp_ok`=1, `ovp`=0, `sleep`=0 and `adp_gt_bat`=1. For every other input combination `bat_gate_en` is 1 and `in_gate_en` is 0.
- R2: `in_gate_en` and `bat_gate_en` are never 1 in the same cycle.
- R3: When one enable drops, both enables stay 0 for exactly DEAD_TICKS clock cycles. At the end of that gap the enable for the path the inputs select at that moment rises, which may be the same path that was just dropped.
- R4: An `ovp` of 1 sampled at a rising edge clears `in_gate_en` at that edge, with no deglitch. Clearing `ovp` while the adapter path is otherwise wanted clears `bat_gate_en` at the next edge.
- R5: An `adp_ok` of 0 sampled at a rising edge clears `in_gate_en` at that edge.
- R6: `sleep` must be sampled at 1 on SLEEP_TICKS consecutive edges before it counts. `in_gate_en` then clears on the following edge. A shorter pulse has no effect, and release takes effect after one edge.
- R7: `adp_gt_bat` must be sampled at 1 on ABV_ON_TICKS consecutive edges before it counts. `bat_gate_en` then clears on the following edge. A shorter pulse has no effect.
- R8: `adp_gt_bat` must be sampled at 0 on ABV_OFF_TICKS consecutive edges before its release counts. `in_gate_en` then clears on the following edge. A shorter dip has no effect.
- R9: While the synchronous `rst` is 1, both enables are 0 and both filters read 0. The first enable rises DEAD_TICKS edges after the first edge with `rst` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adp_ok | input | 1 | Adapter qualified flag |
| ovp | input | 1 | Input over-voltage flag |
| sleep | input | 1 | Input near or below battery flag |
| adp_gt_bat | input | 1 | Adapter voltage above battery flag |
| in_gate_en | output | 1 | Enable for the input FET pair |
| bat_gate_en | output | 1 | Enable for the battery FET |

## Verification
All sixteen combinations of the four flags are held steady in turn. Each one's settled path is compared against the selection rule, which separates the single combination that picks the adapter from the fifteen that pick the battery. Pulses one tick shorter than each deglitch window, and holds of exactly the window length, tell a working filter from one that is off by one or missing. Over-voltage and adapter loss are raised while the adapter path is on, to show that removal takes one edge while the return waits out the gap. A sleep release inside the gap shows that the path is chosen again at the end of the gap.

// File: rtl/pp_switch_pkg.sv
package pp_switch_pkg;

    typedef enum logic [1:0] {
        PATH_GAP = 2'd0,
        PATH_ADP = 2'd1,
        PATH_BAT = 2'd2
    } path_e;

    function automatic int unsigned cnt_width(input int unsigned span);
        return (span > 1) ? $clog2(span) : 1;
    endfunction

endpackage

// File: rtl/pp_flag_filter.sv
module pp_flag_filter #(
    parameter int unsigned RISE_TICKS = 4,
    parameter int unsigned FALL_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level_o
);
    import pp_switch_pkg::*;

    localparam int unsigned SPAN  = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
    localparam int unsigned CNT_W = cnt_width(SPAN);

    generate
        if (RISE_TICKS <= 1 && FALL_TICKS <= 1) begin : g_plain
            logic level_d, level_q;
            always_comb level_d = din;
            always_ff @(posedge clk) begin
                if (rst) level_q <= 1'b0;
                else     level_q <= level_d;
            end
            assign level_o = level_q;
        end else begin : g_count
            localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(RISE_TICKS - 1);
            localparam logic [CNT_W-1:0] FALL_LAST = CNT_W'(FALL_TICKS - 1);

            typedef struct packed {
                logic             level;
                logic [CNT_W-1:0] cnt;
            } filt_t;

            filt_t cur_q, nxt_d;
            logic [CNT_W-1:0] last;

            always_comb begin
                nxt_d = cur_q;
                last  = din ? RISE_LAST : FALL_LAST;
                if (din == cur_q.level) begin
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == last) begin
                    nxt_d.level = din;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) cur_q <= '0;
                else     cur_q <= nxt_d;
            end

            assign level_o = cur_q.level;

            // R6
            cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
                cur_q.cnt <= ((RISE_LAST > FALL_LAST) ? RISE_LAST : FALL_LAST));
        end
    endgenerate

    // R7
    rise_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(level_o) |-> $past(din));

    // R8
    fall_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(level_o) |-> !$past(din));

endmodule

// File: rtl/pp_path_arbiter.sv
module pp_path_arbiter #(
    parameter int unsigned DEAD_TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic want_adp_i,
    output logic in_en_o,
    output logic bat_en_o
);
    import pp_switch_pkg::*;

    localparam int unsigned      CNT_W     = cnt_width(DEAD_TICKS);
    localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_TICKS - 1);

    typedef struct packed {
        path_e            state;
        logic [CNT_W-1:0] cnt;
    } arb_t;

    arb_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.state)
            PATH_ADP: begin
                if (!want_adp_i) begin
                    nxt_d.state = PATH_GAP;
                    nxt_d.cnt   = '0;
                end
            end
            PATH_BAT: begin
                if (want_adp_i) begin
                    nxt_d.state = PATH_GAP;
                    nxt_d.cnt   = '0;
                end
            end
            default: begin
                if (cur_q.cnt == DEAD_LAST) begin
                    nxt_d.state = want_adp_i ? PATH_ADP : PATH_BAT;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '{state: PATH_GAP, cnt: '0};
        else     cur_q <= nxt_d;
    end

    assign in_en_o  = (cur_q.state == PATH_ADP);
    assign bat_en_o = (cur_q.state == PATH_BAT);

    // R2
    never_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_en_o && bat_en_o));

    // R3
    adp_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_en_o) |-> $past(!bat_en_o));

    // R3
    bat_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bat_en_o) |-> $past(!in_en_o));

    // R3
    gap_count_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state != PATH_GAP) |-> (cur_q.cnt == '0));

endmodule

// File: rtl/pp_switch_seq.sv
module pp_switch_seq #(
    parameter int unsigned DEAD_TICKS    = 64,
    parameter int unsigned SLEEP_TICKS   = 1000,
    parameter int unsigned ABV_ON_TICKS  = 500,
    parameter int unsigned ABV_OFF_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic adp_ok,
    input  logic ovp,
    input  logic sleep,
    input  logic adp_gt_bat,
    output logic in_gate_en,
    output logic bat_gate_en
);

    logic sleep_f;
    logic abv_f;
    logic want_adp;

    pp_flag_filter #(
        .RISE_TICKS (SLEEP_TICKS),
        .FALL_TICKS (1)
    ) u_sleep_filt (
        .clk     (clk),
        .rst     (rst),
        .din     (sleep),
        .level_o (sleep_f)
    );

    pp_flag_filter #(
        .RISE_TICKS (ABV_ON_TICKS),
        .FALL_TICKS (ABV_OFF_TICKS)
    ) u_abv_filt (
        .clk     (clk),
        .rst     (rst),
        .din     (adp_gt_bat),
        .level_o (abv_f)
    );

    always_comb want_adp = adp_ok && !ovp && !sleep_f && abv_f;

    pp_path_arbiter #(
        .DEAD_TICKS (DEAD_TICKS)
    ) u_arb (
        .clk        (clk),
        .rst        (rst),
        .want_adp_i (want_adp),
        .in_en_o    (in_gate_en),
        .bat_en_o   (bat_gate_en)
    );

    // R4
    ovp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ovp |=> !in_gate_en);

    // R5
    adp_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !adp_ok |=> !in_gate_en);

    // R6
    sleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_f |=> !in_gate_en);

    // R8
    abv_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !abv_f |=> !in_gate_en);

endmodule

// File: tb/pp_switch_seq_test.sv
module pp_switch_seq_test;

    localparam int unsigned D  = 3;
    localparam int unsigned S  = 4;
    localparam int unsigned AN = 5;
    localparam int unsigned AF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adp_ok = 1'b0, ovp = 1'b0, sleep = 1'b0, adp_gt_bat = 1'b0;
    logic in_gate_en, bat_gate_en;

    int checks = 0;
    int errors = 0;
    int gap = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    pp_switch_seq #(
        .DEAD_TICKS    (D),
        .SLEEP_TICKS   (S),
        .ABV_ON_TICKS  (AN),
        .ABV_OFF_TICKS (AF)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .adp_ok      (adp_ok),
        .ovp         (ovp),
        .sleep       (sleep),
        .adp_gt_bat  (adp_gt_bat),
        .in_gate_en  (in_gate_en),
        .bat_gate_en (bat_gate_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp_in, input logic exp_bat);
        checks++;
        if (in_gate_en !== exp_in || bat_gate_en !== exp_bat) begin
            errors++;
            $display("FAIL %s: in/bat actual %b%b expected %b%b at %0t",
                     req, in_gate_en, bat_gate_en, exp_in, exp_bat, $time);
        end
    endtask

    // Interlock and gap monitor, sampled a quarter period after each edge
    always begin
        @(posedge clk);
        #5;
        if (!done) begin
            checks++;
            if (in_gate_en && bat_gate_en) begin
                errors++;
                $display("FAIL R2: in/bat actual 11 expected not both at %0t", $time);
            end
            if (in_gate_en || bat_gate_en) begin
                if (gap != 0 && gap < D) begin
                    errors++;
                    $display("FAIL R3: gap actual %0d expected >= %0d", gap, D);
                end
                gap = 0;
            end else begin
                gap++;
            end
        end
    end

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        chk("R9 reset", 1'b0, 1'b0);
        rst = 1'b0;
        tick(D - 1);
        chk("R9 gap after reset", 1'b0, 1'b0);
        tick(1);
        chk("R9 battery first", 1'b0, 1'b1);

        // R7: move to adapter
        adp_ok = 1'b1; adp_gt_bat = 1'b1;
        tick(AN);
        chk("R7 still battery", 1'b0, 1'b1);
        tick(1);
        chk("R7 battery off", 1'b0, 1'b0);
        tick(D - 1);
        chk("R3 gap held", 1'b0, 1'b0);
        tick(1);
        chk("R3 adapter on", 1'b1, 1'b0);

        // R6: short sleep pulse then full hold
        sleep = 1'b1;
        tick(S - 1);
        chk("R6 short pulse", 1'b1, 1'b0);
        sleep = 1'b0;
        tick(3);
        chk("R6 short pulse ignored", 1'b1, 1'b0);
        sleep = 1'b1;
        tick(S);
        chk("R6 before deglitch end", 1'b1, 1'b0);
        tick(1);
        chk("R6 input off", 1'b0, 1'b0);
        sleep = 1'b0;
        tick(D - 1);
        chk("R3 gap after sleep", 1'b0, 1'b0);
        tick(1);
        chk("R3 reselect adapter", 1'b1, 1'b0);

        // R4: over-voltage
        ovp = 1'b1;
        tick(1);
        chk("R4 immediate off", 1'b0, 1'b0);
        tick(D - 1);
        chk("R4 gap", 1'b0, 1'b0);
        tick(1);
        chk("R4 battery on", 1'b0, 1'b1);
        ovp = 1'b0;
        tick(1);
        chk("R4 battery off on clear", 1'b0, 0);
        tick(D - 1);
        chk("R4 gap on return", 1'b0, 1'b0);
        tick(1);
        chk("R4 adapter back", 1'b1, 1'b0);

        // R8: adapter-above-battery release
        adp_gt_bat = 1'b0;
        tick(AF - 1);
        chk("R8 short dip", 1'b1, 1'b0);
        adp_gt_bat = 1'b1;
        tick(2);
        chk("R8 short dip ignored", 1'b1, 1'b0);
        adp_gt_bat = 1'b0;
        tick(AF);
        chk("R8 before deglitch end", 1'b1, 1'b0);
        tick(1);
        chk("R8 input off", 1'b0, 1'b0);
        tick(D);
        chk("R8 battery on", 1'b0, 1'b1);

        // R7: short rise ignored, then full rise
        adp_gt_bat = 1'b1;
        tick(AN - 1);
        chk("R7 short rise", 1'b0, 1'b1);
        adp_gt_bat = 1'b0;
        tick(2);
        chk("R7 short rise ignored", 1'b0, 1'b1);
        adp_gt_bat = 1'b1;
        tick(AN + 1 + D);
        chk("R7 adapter after full rise", 1'b1, 1'b0);

        // R5: adapter loss
        adp_ok = 1'b0;
        tick(1);
        chk("R5 immediate off", 1'b0, 1'b0);
        tick(D);
        chk("R5 battery on", 1'b0, 1'b1);

        // R1: exhaustive sweep over the four flags
        for (int c = 0; c < 16; c++) begin
            logic exp_adp;
            adp_ok     = c[0];
            ovp        = c[1];
            sleep      = c[2];
            adp_gt_bat = c[3];
            exp_adp    = c[0] && !c[1] && !c[2] && c[3];
            tick(20);
            chk($sformatf("R1 combo %0d", c), exp_adp, !exp_adp);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule